// File: doc/BRIEF.md
# Always-Taken Branch Fetch Controller

This block chooses the next fetch address for a four-stage in-order pipeline (fetch, decode, execute, writeback) and decides which in-flight slots may change architectural state. Every conditional branch is guessed taken. Fetch follows the branch target in the very next cycle, using a predecode of the word being fetched.

A conditional branch's real outcome arrives only while that branch sits in writeback. If the branch was in fact not taken, the three younger slots already in the pipe are killed. Their register and flag writes are held off, and fetch restarts at the branch's fall-through address.

Unconditional branches are recognised one stage later, in decode. A branch-always sends fetch to its target and leaves one dead slot behind it. A branch-never changes nothing. The controller carries each slot's kind, target and fall-through address down the pipe. It exposes a valid bit per stage and the write enables for the writeback stage.

Top module: `taken_fetch_ctl`

## Requirements
- R1: While reset is held, `fetch_pc` equals `START_PC`, `stage_valid` (bit 0 fetch, bit 1 decode, bit 2 execute, bit 3 writeback) is all zero, and both write enables are low. The first valid fetch is from `START_PC`, in the first cycle after the first clock edge with reset released.
- R2: A valid fetched word of kind 2'b00 (no branch) is followed, one cycle later, by a fetch from its `f_fallthru` address. Valid slots move one stage per cycle.
- R3: A valid fetched word of kind 2'b01 (conditional) is followed, one cycle later, by a fetch from its `f_target`, with no dead slot.
- R4: When a conditional branch resolves taken (`wb_taken` high while it is in writeback), no slot is killed and the write enables stay high every cycle.
- R5: `mispredict` is high exactly while a valid conditional branch is in writeback with `wb_taken` low. The next fetch is from that branch's fall-through address.
- R6: After a mispredict, `rf_we` and `flag_we` are low for the next three cycles. The restarted instruction writes back in the fourth cycle.
- R7: A valid kind 2'b10 (branch-always) in decode sends the next fetch to its target. It leaves exactly one invalid slot, the word fetched behind it.
- R8: A kind 2'b11 (branch-never) redirects nothing and kills nothing.
- R9: A redirect from writeback takes priority over a decode redirect and a fetch-side prediction in the same cycle. Branches in killed slots never redirect fetch.
- R10: `rf_we` and `flag_we` are always equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| f_kind | input | 2 | Predecoded branch kind of the word at `fetch_pc` |
| f_target | input | AW | Branch target of the word at `fetch_pc` |
| f_fallthru | input | AW | Fall-through address of the word at `fetch_pc` |
| wb_taken | input | 1 | Resolved outcome of the branch now in writeback |
| fetch_pc | output | AW | Address being fetched this cycle |
| stage_valid | output | 4 | Per-stage valid bits {W, E, D, F} |
| mispredict | output | 1 | Writeback branch guessed wrong; younger slots killed |
| rf_we | output | 1 | Register-file write enable for the writeback slot |
| flag_we | output | 1 | Condition-flag write enable for the writeback slot |

## Verification
The timing windows are fixed by the design:
- A fetch-side prediction shows on `fetch_pc` one edge after the branch word is fetched.
- A branch-always redirect shows two edges after it is fetched, once it has spent a cycle in decode.
- A mispredict is flagged combinationally three edges after the branch is fetched. The fall-through fetch follows one edge later, and the three dead writeback cycles come after that.

The bench advances one rising edge per step and samples everything at the following falling edge. Every cycle of each scenario is compared against a cycle-indexed expectation for the fetch address, the valid bits, the write enables and the mispredict flag. A timing slip of even one cycle therefore fails a check.

// File: rtl/taken_fetch_ctl.sv
module taken_fetch_ctl #(
  parameter int AW = 32,
  parameter logic [AW-1:0] START_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    f_kind,
  input  logic [AW-1:0] f_target,
  input  logic [AW-1:0] f_fallthru,
  input  logic          wb_taken,
  output logic [AW-1:0] fetch_pc,
  output logic [3:0]    stage_valid,
  output logic          mispredict,
  output logic          rf_we,
  output logic          flag_we
);
  localparam logic [1:0] KIND_COND = 2'b01;
  localparam logic [1:0] KIND_ALW  = 2'b10;

  logic [AW-1:0] pc_q, pc_n;
  logic          f_v, d_v, e_v, w_v;
  logic [1:0]    d_k, e_k, w_k;
  logic [AW-1:0] d_tgt, d_ft, e_ft, w_ft;
  logic          dec_jump, fet_jump, kill_d;

  assign mispredict = w_v && (w_k == KIND_COND) && !wb_taken;
  assign dec_jump   = d_v && (d_k == KIND_ALW) && !mispredict;
  assign fet_jump   = f_v && (f_kind == KIND_COND);
  assign kill_d     = mispredict || dec_jump;

  always_comb begin
    if (mispredict)    pc_n = w_ft;
    else if (dec_jump) pc_n = d_tgt;
    else if (fet_jump) pc_n = f_target;
    else if (f_v)      pc_n = f_fallthru;
    else               pc_n = pc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= START_PC;
      f_v   <= 1'b0;
      d_v   <= 1'b0;
      e_v   <= 1'b0;
      w_v   <= 1'b0;
      d_k   <= '0;
      e_k   <= '0;
      w_k   <= '0;
      d_tgt <= '0;
      d_ft  <= '0;
      e_ft  <= '0;
      w_ft  <= '0;
    end else begin
      pc_q  <= pc_n;
      f_v   <= 1'b1;
      d_v   <= f_v && !kill_d;
      d_k   <= f_kind;
      d_tgt <= f_target;
      d_ft  <= f_fallthru;
      e_v   <= d_v && !mispredict;
      e_k   <= d_k;
      e_ft  <= d_ft;
      w_v   <= e_v && !mispredict;
      w_k   <= e_k;
      w_ft  <= e_ft;
    end
  end

  assign fetch_pc    = pc_q;
  assign stage_valid = {w_v, e_v, d_v, f_v};
  assign rf_we       = w_v;
  assign flag_we     = w_v;
endmodule

// File: rtl/taken_fetch_ctl_chk.sv
module taken_fetch_ctl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    f_kind,
  input logic [AW-1:0] f_target,
  input logic [AW-1:0] fetch_pc,
  input logic [3:0]    stage_valid,
  input logic          mispredict,
  input logic          rf_we,
  input logic          flag_we,
  input logic [1:0]    d_k,
  input logic [AW-1:0] d_tgt,
  input logic [AW-1:0] w_ft
);
  logic alw_in_d;
  assign alw_in_d = stage_valid[1] && (d_k == 2'b10);

  // R5
  mis_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |=> (fetch_pc == $past(w_ft)) && (stage_valid[3:1] == 3'b000));

  // R6
  squash_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |=> (!rf_we && !flag_we) ##1 (!rf_we && !flag_we) ##1 (!rf_we && !flag_we));

  // R7
  dec_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alw_in_d && !mispredict) |=> (fetch_pc == $past(d_tgt)) && !stage_valid[1]);

  // R3
  pred_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_valid[0] && (f_kind == 2'b01) && !mispredict && !alw_in_d)
      |=> (fetch_pc == $past(f_target)));

  // R2
  slot_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mispredict && !alw_in_d) |=> (stage_valid[2:1] == $past(stage_valid[1:0])));
endmodule

bind taken_fetch_ctl taken_fetch_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .f_kind(f_kind), .f_target(f_target),
  .fetch_pc(fetch_pc), .stage_valid(stage_valid), .mispredict(mispredict),
  .rf_we(rf_we), .flag_we(flag_we), .d_k(d_k), .d_tgt(d_tgt), .w_ft(w_ft)
);

// File: tb/tb_taken_fetch_ctl.sv
module tb_taken_fetch_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wb_taken = 1'b1;
  logic [1:0]    f_kind;
  logic [AW-1:0] f_target, f_fallthru, fetch_pc;
  logic [3:0]    stage_valid;
  logic          mispredict, rf_we, flag_we;

  logic [1:0]    kmem [0:63];
  logic [AW-1:0] tmem [0:63];

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign f_kind     = kmem[fetch_pc[7:2]];
  assign f_target   = tmem[fetch_pc[7:2]];
  assign f_fallthru = fetch_pc + 32'd4;

  taken_fetch_ctl #(.AW(AW), .START_PC('0)) dut (
    .clk(clk), .rst_n(rst_n), .f_kind(f_kind), .f_target(f_target),
    .f_fallthru(f_fallthru), .wb_taken(wb_taken), .fetch_pc(fetch_pc),
    .stage_valid(stage_valid), .mispredict(mispredict), .rf_we(rf_we),
    .flag_we(flag_we)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) begin
      kmem[i] = 2'b00;
      tmem[i] = '0;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(fetch_pc == 32'h0, "R1", "reset pc", fetch_pc, 32'h0);
    check(stage_valid == 4'b0, "R1", "reset valid", {28'h0, stage_valid}, 32'h0);
    check(!rf_we && !flag_we, "R1", "reset we", {30'h0, rf_we, flag_we}, 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic [31:0] pc, input logic [3:0] vld,
                      input bit we, input bit mis, input string tag);
    @(posedge clk);
    @(negedge clk);
    check(fetch_pc == pc, tag, "fetch_pc", fetch_pc, pc);
    check(stage_valid == vld, tag, "stage_valid", {28'h0, stage_valid}, {28'h0, vld});
    check(rf_we == we, tag, "rf_we", {31'h0, rf_we}, {31'h0, we});
    check(flag_we == rf_we, "R10", "flag_we", {31'h0, flag_we}, {31'h0, rf_we});
    check(mispredict == mis, tag, "mispredict", {31'h0, mispredict}, {31'h0, mis});
  endtask

  task automatic prologue();
    step(32'h00, 4'b0001, 1'b0, 1'b0, "R1");
    step(32'h04, 4'b0011, 1'b0, 1'b0, "R2");
    step(32'h08, 4'b0111, 1'b0, 1'b0, "R2");
  endtask

  task automatic scen_taken();
    clear_mem();
    kmem[2] = 2'b01; tmem[2] = 32'h40;
    wb_taken = 1'b1;
    do_reset();
    prologue();
    step(32'h40, 4'b1111, 1'b1, 1'b0, "R3");
    step(32'h44, 4'b1111, 1'b1, 1'b0, "R4");
    step(32'h48, 4'b1111, 1'b1, 1'b0, "R4");
    step(32'h4C, 4'b1111, 1'b1, 1'b0, "R4");
    step(32'h50, 4'b1111, 1'b1, 1'b0, "R4");
  endtask

  task automatic scen_mispredict();
    clear_mem();
    kmem[2] = 2'b01; tmem[2] = 32'h40;
    wb_taken = 1'b0;
    do_reset();
    prologue();
    step(32'h40, 4'b1111, 1'b1, 1'b0, "R3");
    step(32'h44, 4'b1111, 1'b1, 1'b0, "R3");
    step(32'h48, 4'b1111, 1'b1, 1'b1, "R5");
    step(32'h0C, 4'b0001, 1'b0, 1'b0, "R5");
    step(32'h10, 4'b0011, 1'b0, 1'b0, "R6");
    step(32'h14, 4'b0111, 1'b0, 1'b0, "R6");
    step(32'h18, 4'b1111, 1'b1, 1'b0, "R6");
  endtask

  task automatic scen_always();
    clear_mem();
    kmem[2] = 2'b10; tmem[2] = 32'h40;
    wb_taken = 1'b0;
    do_reset();
    prologue();
    step(32'h0C, 4'b1111, 1'b1, 1'b0, "R7");
    step(32'h40, 4'b1101, 1'b1, 1'b0, "R7");
    step(32'h44, 4'b1011, 1'b1, 1'b0, "R7");
    step(32'h48, 4'b0111, 1'b0, 1'b0, "R7");
    step(32'h4C, 4'b1111, 1'b1, 1'b0, "R7");
  endtask

  task automatic scen_never();
    clear_mem();
    kmem[2] = 2'b11; tmem[2] = 32'h40;
    wb_taken = 1'b0;
    do_reset();
    prologue();
    step(32'h0C, 4'b1111, 1'b1, 1'b0, "R8");
    step(32'h10, 4'b1111, 1'b1, 1'b0, "R8");
    step(32'h14, 4'b1111, 1'b1, 1'b0, "R8");
    step(32'h18, 4'b1111, 1'b1, 1'b0, "R8");
  endtask

  task automatic scen_squashed();
    clear_mem();
    kmem[2]  = 2'b01; tmem[2]  = 32'h40;
    kmem[17] = 2'b10; tmem[17] = 32'hC0;
    kmem[18] = 2'b01; tmem[18] = 32'hE0;
    wb_taken = 1'b0;
    do_reset();
    prologue();
    step(32'h40, 4'b1111, 1'b1, 1'b0, "R3");
    step(32'h44, 4'b1111, 1'b1, 1'b0, "R3");
    step(32'h48, 4'b1111, 1'b1, 1'b1, "R9");
    step(32'h0C, 4'b0001, 1'b0, 1'b0, "R9");
    step(32'h10, 4'b0011, 1'b0, 1'b0, "R9");
    step(32'h14, 4'b0111, 1'b0, 1'b0, "R9");
    step(32'h18, 4'b1111, 1'b1, 1'b0, "R9");
    step(32'h1C, 4'b1111, 1'b1, 1'b0, "R9");
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    scen_taken();
    scen_mispredict();
    scen_always();
    scen_never();
    scen_squashed();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule